// File: doc/BRIEF.md
# Context-Address Association Queue

This block keeps a running history of memory accesses for an online-trained address predictor and turns that history into training pairs. Every access brings a context state vector, its address, its cache-hit status and the neuron values the predictor produced for it. The record is written into a circular queue. Once the queue is full, each new access evicts the oldest record, and that record becomes the training context. The queue depth therefore sets how far ahead the predictor learns to look.

For the evicted context the block picks one training target from a small window of the newest stored records. Each candidate's delta is its address minus the evicted address. Cache hits that were not brought in by a prefetch take a slot but are never candidates. A programmable magnitude limit rejects far deltas. A small table indexed by a fold of the context remembers the delta last chosen for that context, and a candidate with that delta wins. Without such a match, the candidate whose delta agrees with the supplied prediction bits in the most positions wins. The chosen delta comes out with the evicted context, address and neuron values one cycle after the access.

Top module: `ctx_assoc_queue`

## Requirements
- R1: Each cycle with `acc_valid_i` high stores one record at the head. Once `DEPTH` (default 128, a power of two) records are held, each such cycle evicts the oldest record. The evicted context and address appear on the training outputs in the next cycle when a pair is issued.
- R2: After reset no pair is issued for the first `DEPTH` accesses, and `train_valid_o` is 0 out of reset.
- R3: The candidates for an eviction are the `WIN` (default 8) records stored most recently before the current access. The current access and the evicted record are never candidates.
- R4: A record whose `acc_l1_hit_i` was 1 and `acc_pf_hit_i` was 0 keeps its queue slot but is never chosen.
- R5: A record with `acc_pf_hit_i` equal to 1 counts as eligible even when `acc_l1_hit_i` is 1.
- R6: When no table match applies, the chosen candidate maximises the number of bit positions in which its delta (candidate address minus evicted address, modulo 2^ADDR_W) equals `pred_bits_i`, and `train_src_o` is 2.
- R7: The hint table has 64 entries. Its index is an XOR fold in which context bit i goes to index bit (i mod 6). Every issued pair writes its delta into the entry of its context, and reset marks all entries empty. If the evicted context's entry is filled and an eligible candidate has exactly that delta, the newest such candidate is chosen and `train_src_o` is 1.
- R8: The neuron values given with an access are returned on `train_nrn_o` when that record is evicted.
- R9: A candidate whose delta, read as two's complement, has a magnitude above `max_delta_i` is rejected.
- R10: Among candidates with equal best match count, the newest wins.
- R11: If no candidate qualifies, `train_valid_o` stays 0 for that eviction and `train_src_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_ctx_i | input | CTX_W | Context state vector of the access |
| acc_addr_i | input | ADDR_W | Access address |
| acc_l1_hit_i | input | 1 | Access hit in the first-level cache |
| acc_pf_hit_i | input | 1 | Access hit a line installed by a prefetch |
| acc_nrn_i | input | NRN_W | Neuron values captured at inference |
| pred_bits_i | input | ADDR_W | Predictor output bits for the evicted context |
| max_delta_i | input | ADDR_W | Largest accepted delta magnitude |
| train_valid_o | output | 1 | A training pair is issued |
| train_ctx_o | output | CTX_W | Evicted context |
| train_addr_o | output | ADDR_W | Evicted address |
| train_nrn_o | output | NRN_W | Evicted neuron values |
| train_delta_o | output | ADDR_W | Chosen target delta |
| train_src_o | output | 2 | 0 none, 1 table match, 2 bit match |

## Verification
The assertions assume that `pred_bits_i` and `max_delta_i` belong to the eviction of the access presented in the same cycle. The magnitude check compares against the previous cycle's limit on that basis. They also assume that accesses start only after reset is released, since their own count of accesses starts there. The bench drives each access for exactly one cycle with its prediction and limit held alongside it, and it keeps all inputs idle between accesses and around resets.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HINT  = 2'd1,
    SRC_MATCH = 2'd2
  } src_e;
endpackage

// File: rtl/assoc_ring.sv
module assoc_ring #(
  parameter int DEPTH  = 128,
  parameter int CTX_W  = 32,
  parameter int ADDR_W = 32,
  parameter int NRN_W  = 16,
  parameter int WIN    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic [CTX_W-1:0]              ctx_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          elig_i,
  input  logic [NRN_W-1:0]              nrn_i,
  output logic                          pop_o,
  output logic [CTX_W-1:0]              pop_ctx_o,
  output logic [ADDR_W-1:0]             pop_addr_o,
  output logic [NRN_W-1:0]              pop_nrn_o,
  output logic [WIN-1:0]                cand_ok_o,
  output logic [WIN-1:0]                cand_elig_o,
  output logic [WIN-1:0][ADDR_W-1:0]    cand_addr_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CTX_W-1:0]  ctx_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [NRN_W-1:0]  nrn_q  [DEPTH];
  logic [DEPTH-1:0]  elig_q;
  logic [PTR_W-1:0]  head_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full;

  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign pop_o      = push_i && full;
  // when full the head slot is the oldest record
  assign pop_ctx_o  = ctx_q[head_q];
  assign pop_addr_o = addr_q[head_q];
  assign pop_nrn_o  = nrn_q[head_q];

  for (genvar k = 0; k < WIN; k++) begin : g_cand
    logic [PTR_W-1:0] idx;
    assign idx            = head_q - PTR_W'(k + 1);
    assign cand_ok_o[k]   = (cnt_q > CNT_W'(k));
    assign cand_elig_o[k] = elig_q[idx];
    assign cand_addr_o[k] = addr_q[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (push_i) begin
      head_q <= head_q + PTR_W'(1);
      if (!full) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      ctx_q[head_q]  <= ctx_i;
      addr_q[head_q] <= addr_i;
      nrn_q[head_q]  <= nrn_i;
      elig_q[head_q] <= elig_i;
    end
  end
endmodule

// File: rtl/ctx_hint_table.sv
module ctx_hint_table #(
  parameter int CTX_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdelta_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] delta_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ADDR_W-1:0]  delta_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [IDX_W-1:0]   idx;

  always_comb begin
    idx = '0;
    for (int i = 0; i < CTX_W; i++) idx[i % IDX_W] = idx[i % IDX_W] ^ ctx_i[i];
  end

  assign hit_o   = vld_q[idx];
  assign delta_o = delta_q[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q      <= '0;
    else if (we_i) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) delta_q[idx] <= wdelta_i;
  end
endmodule

// File: rtl/cand_pick.sv
module cand_pick
  import assoc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN    = 8
) (
  input  logic [WIN-1:0]             cand_ok_i,
  input  logic [WIN-1:0]             cand_elig_i,
  input  logic [WIN-1:0][ADDR_W-1:0] cand_addr_i,
  input  logic [ADDR_W-1:0]          base_addr_i,
  input  logic [ADDR_W-1:0]          pred_i,
  input  logic [ADDR_W-1:0]          limit_i,
  input  logic                       hint_vld_i,
  input  logic [ADDR_W-1:0]          hint_delta_i,
  output logic                       pick_vld_o,
  output logic [1:0]                 pick_src_o,
  output logic [ADDR_W-1:0]          pick_delta_o
);
  localparam int SC_W = $clog2(ADDR_W + 1);
  localparam int K_W  = (WIN > 1) ? $clog2(WIN) : 1;

  function automatic logic [SC_W-1:0] ones(input logic [ADDR_W-1:0] v);
    logic [SC_W-1:0] s;
    s = '0;
    for (int b = 0; b < ADDR_W; b++) s = s + SC_W'(v[b]);
    return s;
  endfunction

  logic [ADDR_W-1:0] delta_w [WIN];
  logic [SC_W-1:0]   score_w [WIN];
  logic [WIN-1:0]    qual_w;
  logic [WIN-1:0]    hint_w;

  for (genvar k = 0; k < WIN; k++) begin : g_q
    logic [ADDR_W-1:0] mag;
    assign delta_w[k] = cand_addr_i[k] - base_addr_i;
    assign mag        = delta_w[k][ADDR_W-1] ? (~delta_w[k] + ADDR_W'(1)) : delta_w[k];
    assign qual_w[k]  = cand_ok_i[k] && cand_elig_i[k] && (mag <= limit_i);
    assign hint_w[k]  = qual_w[k] && hint_vld_i && (delta_w[k] == hint_delta_i);
    assign score_w[k] = ones(~(delta_w[k] ^ pred_i));
  end

  logic            hit_f, best_f;
  logic [K_W-1:0]  hit_k, best_k;
  logic [SC_W-1:0] best_s;

  // scan oldest to newest so the newest wins on equality
  always_comb begin
    hit_f  = 1'b0;
    hit_k  = '0;
    best_f = 1'b0;
    best_k = '0;
    best_s = '0;
    for (int k = WIN - 1; k >= 0; k--) begin
      if (hint_w[k]) begin
        hit_f = 1'b1;
        hit_k = K_W'(k);
      end
      if (qual_w[k] && (!best_f || score_w[k] >= best_s)) begin
        best_f = 1'b1;
        best_k = K_W'(k);
        best_s = score_w[k];
      end
    end
  end

  assign pick_vld_o   = best_f;
  assign pick_src_o   = hit_f ? SRC_HINT : (best_f ? SRC_MATCH : SRC_NONE);
  assign pick_delta_o = hit_f ? delta_w[hit_k] : delta_w[best_k];
endmodule

// File: rtl/ctx_assoc_queue.sv
module ctx_assoc_queue
  import assoc_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int CTX_W     = 32,
  parameter int ADDR_W    = 32,
  parameter int NRN_W     = 16,
  parameter int WIN       = 8,
  parameter int HINT_ENTR = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [CTX_W-1:0]  acc_ctx_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_l1_hit_i,
  input  logic              acc_pf_hit_i,
  input  logic [NRN_W-1:0]  acc_nrn_i,
  input  logic [ADDR_W-1:0] pred_bits_i,
  input  logic [ADDR_W-1:0] max_delta_i,
  output logic              train_valid_o,
  output logic [CTX_W-1:0]  train_ctx_o,
  output logic [ADDR_W-1:0] train_addr_o,
  output logic [NRN_W-1:0]  train_nrn_o,
  output logic [ADDR_W-1:0] train_delta_o,
  output logic [1:0]        train_src_o
);
  logic                       pop;
  logic [CTX_W-1:0]           pop_ctx;
  logic [ADDR_W-1:0]          pop_addr;
  logic [NRN_W-1:0]           pop_nrn;
  logic [WIN-1:0]             cand_ok, cand_elig;
  logic [WIN-1:0][ADDR_W-1:0] cand_addr;
  logic                       hint_vld;
  logic [ADDR_W-1:0]          hint_delta;
  logic                       pick_vld;
  logic [1:0]                 pick_src;
  logic [ADDR_W-1:0]          pick_delta;
  logic                       issue;

  assign issue = pop && pick_vld;

  assoc_ring #(
    .DEPTH(DEPTH), .CTX_W(CTX_W), .ADDR_W(ADDR_W), .NRN_W(NRN_W), .WIN(WIN)
  ) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (acc_valid_i),
    .ctx_i       (acc_ctx_i),
    .addr_i      (acc_addr_i),
    .elig_i      (!acc_l1_hit_i || acc_pf_hit_i),
    .nrn_i       (acc_nrn_i),
    .pop_o       (pop),
    .pop_ctx_o   (pop_ctx),
    .pop_addr_o  (pop_addr),
    .pop_nrn_o   (pop_nrn),
    .cand_ok_o   (cand_ok),
    .cand_elig_o (cand_elig),
    .cand_addr_o (cand_addr)
  );

  ctx_hint_table #(
    .CTX_W(CTX_W), .ADDR_W(ADDR_W), .ENTRIES(HINT_ENTR)
  ) u_hint (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctx_i    (pop_ctx),
    .we_i     (issue),
    .wdelta_i (pick_delta),
    .hit_o    (hint_vld),
    .delta_o  (hint_delta)
  );

  cand_pick #(
    .ADDR_W(ADDR_W), .WIN(WIN)
  ) u_pick (
    .cand_ok_i    (cand_ok),
    .cand_elig_i  (cand_elig),
    .cand_addr_i  (cand_addr),
    .base_addr_i  (pop_addr),
    .pred_i       (pred_bits_i),
    .limit_i      (max_delta_i),
    .hint_vld_i   (hint_vld),
    .hint_delta_i (hint_delta),
    .pick_vld_o   (pick_vld),
    .pick_src_o   (pick_src),
    .pick_delta_o (pick_delta)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      train_valid_o <= 1'b0;
      train_src_o   <= SRC_NONE;
      train_ctx_o   <= '0;
      train_addr_o  <= '0;
      train_nrn_o   <= '0;
      train_delta_o <= '0;
    end else begin
      train_valid_o <= issue;
      train_src_o   <= issue ? pick_src : SRC_NONE;
      if (pop) begin
        train_ctx_o   <= pop_ctx;
        train_addr_o  <= pop_addr;
        train_nrn_o   <= pop_nrn;
        train_delta_o <= pick_delta;
      end
    end
  end
endmodule

// File: rtl/ctx_assoc_queue_chk.sv
module ctx_assoc_queue_chk #(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] max_delta_i,
  input logic              train_valid_o,
  input logic [ADDR_W-1:0] train_delta_o,
  input logic [1:0]        train_src_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] seen_q;
  logic             evict_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= '0;
      evict_q <= 1'b0;
    end else begin
      evict_q <= acc_valid_i && (seen_q == CNT_W'(DEPTH));
      if (acc_valid_i && seen_q != CNT_W'(DEPTH)) seen_q <= seen_q + CNT_W'(1);
    end
  end

  function automatic logic [ADDR_W-1:0] mag(input logic [ADDR_W-1:0] d);
    return d[ADDR_W-1] ? (~d + ADDR_W'(1)) : d;
  endfunction

  assert_pair_after_access_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_valid_o |-> $past(acc_valid_i));

  assert_no_pair_before_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_valid_o |-> evict_q);

  assert_delta_in_limit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_valid_o |-> (mag(train_delta_o) <= $past(max_delta_i)));

  assert_src_on_issue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_valid_o |-> (train_src_o == 2'd1 || train_src_o == 2'd2));

  assert_src_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !train_valid_o |-> (train_src_o == 2'd0));
endmodule

bind ctx_assoc_queue ctx_assoc_queue_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_valid_i   (acc_valid_i),
  .max_delta_i   (max_delta_i),
  .train_valid_o (train_valid_o),
  .train_delta_o (train_delta_o),
  .train_src_o   (train_src_o)
);

// File: tb/ctx_assoc_queue_tb_top.sv
`timescale 1ns/1ps
module ctx_assoc_queue_tb_top;
  localparam int DEPTH = 128;
  localparam int WIN   = 8;
  localparam int HENT  = 64;
  localparam int HMAX  = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_ctx = '0, acc_addr = '0, pred = '0, maxd = '0;
  logic        l1_hit = 1'b0, pf_hit = 1'b0;
  logic [15:0] acc_nrn = '0;
  logic        t_valid;
  logic [31:0] t_ctx, t_addr, t_delta;
  logic [15:0] t_nrn;
  logic [1:0]  t_src;

  int checks = 0, errors = 0;
  int n_acc = 0, n_hint = 0, n_match = 0;
  logic [31:0] rnd = 32'h1234_5678;

  logic [31:0] h_ctx [HMAX];
  logic [31:0] h_addr[HMAX];
  logic [15:0] h_nrn [HMAX];
  logic        h_elig[HMAX];
  logic        mh_v  [HENT];
  logic [31:0] mh_d  [HENT];

  always #10 clk = ~clk;

  ctx_assoc_queue dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_ctx_i(acc_ctx),
    .acc_addr_i(acc_addr), .acc_l1_hit_i(l1_hit), .acc_pf_hit_i(pf_hit),
    .acc_nrn_i(acc_nrn), .pred_bits_i(pred), .max_delta_i(maxd),
    .train_valid_o(t_valid), .train_ctx_o(t_ctx), .train_addr_o(t_addr),
    .train_nrn_o(t_nrn), .train_delta_o(t_delta), .train_src_o(t_src)
  );

  function automatic logic [31:0] next_rnd(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic int fold6(input logic [31:0] c);
    logic [5:0] ix;
    ix = '0;
    for (int i = 0; i < 32; i++) ix[i % 6] = ix[i % 6] ^ c[i];
    return int'(ix);
  endfunction

  function automatic int ones32(input logic [31:0] v);
    int s;
    s = 0;
    for (int b = 0; b < 32; b++) s += int'(v[b]);
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    acc_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_acc = 0;
    for (int i = 0; i < HENT; i++) mh_v[i] = 1'b0;
    @(negedge clk);
  endtask

  // one access, model-predicted result checked the cycle after
  task automatic do_access(input logic [31:0] c, input logic [31:0] a, input logic l1,
                           input logic pf, input logic [15:0] nv, input logic [31:0] pb,
                           input logic [31:0] md, input string tag);
    bit          e_vld, hf, bf;
    logic [31:0] e_delta, d, m;
    logic [1:0]  e_src;
    int          p, hx, bs, sc, ix;
    e_vld = 1'b0; e_delta = '0; e_src = 2'd0; hf = 1'b0; bf = 1'b0; bs = -1; p = 0; ix = 0;
    if (n_acc >= DEPTH) begin
      p  = n_acc - DEPTH;
      ix = fold6(h_ctx[p]);
      for (int k = WIN - 1; k >= 0; k--) begin
        hx = n_acc - 1 - k;
        d  = h_addr[hx] - h_addr[p];
        m  = d[31] ? -d : d;
        if (h_elig[hx] && m <= md) begin
          if (mh_v[ix] && d == mh_d[ix]) begin hf = 1'b1; e_delta = d; end
          sc = ones32(~(d ^ pb));
          if (!hf && sc >= bs) begin bf = 1'b1; bs = sc; e_delta = d; end
          else if (sc >= bs) begin bf = 1'b1; bs = sc; end
        end
      end
      // recompute the delta when a table match exists (newest matching)
      if (hf) begin
        for (int k = WIN - 1; k >= 0; k--) begin
          hx = n_acc - 1 - k;
          d  = h_addr[hx] - h_addr[p];
          m  = d[31] ? -d : d;
          if (h_elig[hx] && m <= md && d == mh_d[ix]) e_delta = d;
        end
      end
      e_vld = bf;
      e_src = hf ? 2'd1 : (bf ? 2'd2 : 2'd0);
      if (e_vld) begin mh_v[ix] = 1'b1; mh_d[ix] = e_delta; end
    end
    h_ctx[n_acc] = c; h_addr[n_acc] = a; h_nrn[n_acc] = nv; h_elig[n_acc] = !l1 || pf;
    n_acc++;
    @(negedge clk);
    acc_valid = 1'b1; acc_ctx = c; acc_addr = a; l1_hit = l1; pf_hit = pf;
    acc_nrn = nv; pred = pb; maxd = md;
    @(negedge clk);
    acc_valid = 1'b0;
    check(t_valid == e_vld && t_src == e_src, tag, "valid/src",
          {62'd0, t_valid, 1'b0} | 64'(t_src), {62'd0, e_vld, 1'b0} | 64'(e_src));
    if (e_vld && t_valid) begin
      check(t_delta == e_delta, tag, "delta", 64'(t_delta), 64'(e_delta));
      check(t_ctx == h_ctx[p] && t_addr == h_addr[p], tag, "ctx/addr R1",
            {t_ctx, t_addr}, {h_ctx[p], h_addr[p]});
      check(t_nrn == h_nrn[p], "R8", "neuron", 64'(t_nrn), 64'(h_nrn[p]));
      if (t_src == 2'd1) n_hint++;
      if (t_src == 2'd2) n_match++;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check(t_valid == 1'b0 && t_src == 2'd0, "R2", "reset valid", 64'(t_valid), 64'd0);
  endtask

  task automatic t_stream();
    do_reset();
    for (int i = 0; i < DEPTH + 48; i++) begin
      rnd = next_rnd(rnd);
      do_access(rnd, 32'h8000 + 32'(i * 64) + {24'd0, rnd[7:0]}, 1'b0, 1'b0,
                rnd[15:0] ^ 16'h5a5a, next_rnd(rnd), 32'hFFFF_FFFF,
                (i < DEPTH) ? "R2" : "R6 R3");
    end
  endtask

  task automatic t_filter();
    do_reset();
    for (int i = 0; i < DEPTH; i++)
      do_access(32'(i), 32'h1_0000 + 32'(i * 16), 1'b0, 1'b0, 16'(i), 32'd0, 32'hFFFF_FFFF, "R2");
    // window becomes L1 hits only: slots taken, nothing eligible
    for (int i = 0; i < WIN + 4; i++)
      do_access(32'(100 + i), 32'h2_0000 + 32'(i * 8), 1'b1, 1'b0, 16'(i), 32'h40,
                32'hFFFF_FFFF, "R4 R11");
    // prefetch-installed hits become eligible again
    for (int i = 0; i < WIN + 4; i++)
      do_access(32'(200 + i), 32'h3_0000 + 32'(i * 8), 1'b1, 1'b1, 16'(i), 32'h40,
                32'hFFFF_FFFF, "R5");
  endtask

  task automatic t_limit();
    do_reset();
    for (int i = 0; i < DEPTH; i++)
      do_access(32'(i * 3), 32'(i) * 32'h1_0000, 1'b0, 1'b0, 16'(i), 32'd0, 32'hFFFF_FFFF, "R2");
    for (int i = 0; i < 6; i++)
      do_access(32'(7 + i), 32'h0F00_0000, 1'b0, 1'b0, 16'(i), 32'd0, 32'h100, "R9 R11");
    for (int i = 0; i < 6; i++)
      do_access(32'(9 + i), 32'h0F00_0000, 1'b0, 1'b0, 16'(i), 32'd0, 32'h0100_0000, "R9");
  endtask

  task automatic t_ties();
    logic [31:0] a;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      a = 32'h4000;
      if (i >= DEPTH - WIN) a = 32'h4300;
      if (i == DEPTH - 2) a = 32'h4002;
      if (i == DEPTH - 1) a = 32'h4001;
      do_access(32'(i) << 8, a, 1'b0, 1'b0, 16'(i), 32'd0, 32'hFFFF_FFFF, "R2");
    end
    do_access(32'hABC, 32'h5000, 1'b0, 1'b0, 16'h1, 32'd0, 32'hFFFF_FFFF, "R10");
    check(t_delta == 32'd1, "R10", "newest tie", 64'(t_delta), 64'd1);
  endtask

  task automatic t_hint();
    do_reset();
    n_hint = 0; n_match = 0;
    for (int i = 0; i < DEPTH + 96; i++) begin
      rnd = next_rnd(rnd);
      do_access(32'(i % 16), 32'((i % 16) * 64) + 32'((i / 16) * 32'h400), 1'b0, 1'b0,
                16'(i), rnd, 32'hFFFF_FFFF, "R7");
    end
    check(n_hint > 0, "R7", "table matches seen", 64'(n_hint), 64'd1);
    check(n_match > 0, "R6", "bit matches seen", 64'(n_match), 64'd1);
  endtask

  initial begin
    t_reset_state();
    t_stream();
    t_filter();
    t_limit();
    t_ties();
    t_hint();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule